// File: doc/BRIEF.md
# Glitch-Free Power-of-Two Clock Prescaler

This block sets the rate of the system clock that feeds the CPU and every synchronous peripheral domain. It works from any source clock. A free-running counter runs on the source clock. A one-source-cycle, registered enable pulse is produced once per divided period. Downstream, a clock-gating cell (or the enable pins of the clocked logic) turns that pulse stream into the divided clock. The block never gates the source clock through combinational logic, so every change on its output comes from a flip-flop.

Software selects the division factor by writing a 4-bit exponent code together with a write strobe. Factors from 1 to 256 are available. The new factor is not applied at once. The block holds it until the free-running counter reaches a boundary shared by the old and the new period, and switches there. Because of this, no pulse interval during a change is shorter than either the old or the new period. A busy flag is high while a change is waiting. A newer write replaces the waiting target. After reset the factor is 8.

Top module: `clk_prescaler`

## Requirements
- R1: The output is a stream of enable pulses, each one source cycle wide and driven from a register. The spacing between pulses is the divided period. With code 0 the output is high on every cycle.
- R2: While reset is high, the enable and busy outputs are low. After reset the factor is 8 (code 3), so pulses are 8 cycles apart.
- R3: Codes 0 to 8 select a period of 2^code source cycles.
- R4: An accepted write (strobe high with a code from 0 to 8) drives busy high, seen after the first clock edge that follows the strobe.
- R5: A write with a code from 9 to 15 is ignored. Busy stays low and the pulse spacing does not change.
- R6: A change takes effect, and busy falls, no more than 2^max(old,new) cycles after the write. The change happens only at a counter value that is a boundary of both the old and the new period.
- R7: While a change is in progress, every pulse spacing equals either the old period or the new period. No spacing is shorter than both.
- R8: Once busy has fallen, every pulse spacing equals the new period.
- R9: A write that arrives while busy replaces the waiting target. The final factor is the one from the latest write, and no spacing differs from the periods of the settings involved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock |
| rst_i | input | 1 | Synchronous active-high reset |
| div_we_i | input | 1 | Write strobe for the division code |
| div_code_i | input | 4 | Division exponent code, 0 to 8 valid |
| clk_en_o | output | 1 | Registered enable pulse, once per divided period |
| busy_o | output | 1 | High while a change of factor is waiting |

## Verification
Busy is due one edge after the strobe, so the bench samples it at the falling edge that follows the write. The enable pulse comes one register after the counter value that qualifies it. For that reason the bench never predicts an absolute pulse time. It measures the spacing between consecutive pulses seen at falling edges and compares each spacing with 2^code computed in the bench. The switch delay is counted in falling edges from the write until busy drops and is bounded by 2^max(old,new). Every pair of old and new codes is swept.

// File: rtl/clk_prescaler_pkg.sv
package clk_prescaler_pkg;

    localparam int MAX_K   = 8;                 // largest exponent code
    localparam int CODE_W  = 4;                 // width of the code field
    localparam int CNT_W   = MAX_K;             // counter spans the longest period
    localparam int RESET_K = 3;                 // factor 8 after reset

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef struct packed {
        logic  valid;
        code_t k;
    } pend_t;

    // True when counter value c sits on a period boundary of 2^k.
    function automatic logic on_boundary(cnt_t c, code_t k);
        logic [CNT_W:0] one_hot;
        logic [CNT_W:0] low_mask;
        one_hot  = (CNT_W+1)'(1) << k;
        low_mask = one_hot - (CNT_W+1)'(1);
        return (c & low_mask[CNT_W-1:0]) == '0;
    endfunction

    function automatic code_t kmax(code_t a, code_t b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/prescale_counter.sv
module prescale_counter
    import clk_prescaler_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    output cnt_t cnt_o
);
    cnt_t cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) cnt_q <= '0;
        else       cnt_q <= cnt_q + cnt_t'(1);
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/prescale_ctrl.sv
module prescale_ctrl
    import clk_prescaler_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_i,
    input  logic  we_i,
    input  code_t code_i,
    input  cnt_t  cnt_i,
    output code_t cur_k_o,
    output code_t pend_k_o,
    output logic  busy_o
);
    code_t cur_q;
    pend_t pend_q;
    logic  wr_ok;
    logic  swap;

    assign wr_ok = we_i && (code_i <= code_t'(MAX_K));
    assign swap  = pend_q.valid && on_boundary(cnt_i, kmax(cur_q, pend_q.k));

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cur_q  <= code_t'(RESET_K);
            pend_q <= '0;
        end else begin
            if (swap)
                cur_q <= pend_q.k;
            if (wr_ok)
                pend_q <= '{valid: 1'b1, k: code_i};
            else if (swap)
                pend_q.valid <= 1'b0;
        end
    end

    assign cur_k_o  = cur_q;
    assign pend_k_o = pend_q.k;
    assign busy_o   = pend_q.valid;
endmodule

// File: rtl/prescale_tick.sv
module prescale_tick
    import clk_prescaler_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_i,
    input  cnt_t  cnt_i,
    input  code_t cur_k_i,
    output logic  tick_o
);
    logic tick_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) tick_q <= 1'b0;
        else       tick_q <= on_boundary(cnt_i, cur_k_i);
    end

    assign tick_o = tick_q;
endmodule

// File: rtl/clk_prescaler.sv
module clk_prescaler
    import clk_prescaler_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic        div_we_i,
    input  logic [3:0]  div_code_i,
    output logic        clk_en_o,
    output logic        busy_o
);
    cnt_t  cnt;
    code_t cur_k;
    code_t pend_k;

    prescale_counter u_cnt (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .cnt_o (cnt)
    );

    prescale_ctrl u_ctrl (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .we_i     (div_we_i),
        .code_i   (div_code_i),
        .cnt_i    (cnt),
        .cur_k_o  (cur_k),
        .pend_k_o (pend_k),
        .busy_o   (busy_o)
    );

    prescale_tick u_tick (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .cnt_i   (cnt),
        .cur_k_i (cur_k),
        .tick_o  (clk_en_o)
    );
endmodule

// File: rtl/clk_prescaler_chk.sv
module clk_prescaler_chk
    import clk_prescaler_pkg::*;
(
    input logic       clk_i,
    input logic       rst_i,
    input logic       div_we_i,
    input logic [3:0] div_code_i,
    input logic       clk_en_o,
    input logic       busy_o,
    input cnt_t       cnt,
    input code_t      cur_k,
    input code_t      pend_k
);
    logic [CNT_W:0] gap_q;
    logic           seen_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (clk_en_o) begin
            gap_q  <= (CNT_W+1)'(1);
            seen_q <= 1'b1;
        end else if (gap_q != '1) begin
            gap_q  <= gap_q + (CNT_W+1)'(1);
        end
    end

    AST_GAP_POW2: assert property (@(posedge clk_i) disable iff (rst_i)
        (clk_en_o && seen_q) |-> ($countones(gap_q) == 1));                    // R7

    AST_GAP_MAX: assert property (@(posedge clk_i) disable iff (rst_i)
        seen_q |-> (gap_q <= (CNT_W+1)'(1 << MAX_K)));                          // R1

    AST_CODE_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
        cur_k <= code_t'(MAX_K));                                               // R3

    AST_BUSY_ON_WRITE: assert property (@(posedge clk_i) disable iff (rst_i)
        (div_we_i && div_code_i <= code_t'(MAX_K)) |=> busy_o);                 // R4

    AST_IGNORED_CODE: assert property (@(posedge clk_i) disable iff (rst_i)
        (div_we_i && div_code_i > code_t'(MAX_K) && !busy_o) |=> (!busy_o && $stable(cur_k))); // R5

    AST_SWAP_ALIGNED: assert property (@(posedge clk_i) disable iff (rst_i)
        (cur_k != $past(cur_k)) |-> on_boundary($past(cnt), kmax($past(cur_k), cur_k))); // R6

    AST_BUSY_DROP: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(busy_o) |-> (cur_k == $past(pend_k)));                            // R8
endmodule

bind clk_prescaler clk_prescaler_chk u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .div_we_i   (div_we_i),
    .div_code_i (div_code_i),
    .clk_en_o   (clk_en_o),
    .busy_o     (busy_o),
    .cnt        (cnt),
    .cur_k      (cur_k),
    .pend_k     (pend_k)
);

// File: tb/clk_prescaler_tb.sv
module clk_prescaler_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       we  = 1'b0;
    logic [3:0] code = '0;
    logic       en;
    logic       busy;

    always #10 clk = ~clk;

    clk_prescaler u_dut (
        .clk_i      (clk),
        .rst_i      (rst),
        .div_we_i   (we),
        .div_code_i (code),
        .clk_en_o   (en),
        .busy_o     (busy)
    );

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    int last_tick = -1;
    int gap = 0;
    logic got = 1'b0;
    logic done = 1'b0;
    int cur_tb = 3;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Advance to the next falling edge and record any pulse and its spacing.
    task automatic step();
        @(negedge clk);
        cyc++;
        got = en;
        if (en) begin
            gap = (last_tick < 0) ? 0 : cyc - last_tick;
            last_tick = cyc;
        end
    endtask

    task automatic write(input int c);
        code = 4'(c);
        we = 1'b1;
        step();
        we = 1'b0;
    endtask

    function automatic bit gap_in(int g, int a, int b, int c);
        return (g == 0) || (g == (1 << a)) || (g == (1 << b)) || (g == (1 << c));
    endfunction

    // Count n pulses and check that each spacing equals 2^k.
    task automatic expect_gaps(input int n, input int k, input string req);
        int seen = 0;
        int guard = 0;
        int bad = -1;
        while (seen < n && guard < 4000) begin
            step();
            guard++;
            if (got) begin
                seen++;
                if (gap != 0 && gap != (1 << k)) bad = gap;
            end
        end
        check(seen == n, req, "pulse count", seen, n);
        check(bad < 0, req, "steady spacing", bad, 1 << k);
    endtask

    // Optional first write (pre_k >= 0), then a write of new_k; check the change.
    task automatic apply(input int pre_k, input int new_k);
        int old_k = cur_tb;
        int mid_k = (pre_k >= 0) ? pre_k : old_k;
        int m = old_k;
        int waited = 0;
        int bad = -1;
        if (mid_k > m) m = mid_k;
        if (new_k > m) m = new_k;
        if (pre_k >= 0) begin
            write(pre_k);
            if (got && !gap_in(gap, old_k, mid_k, new_k)) bad = gap;
        end
        write(new_k);
        if (got && !gap_in(gap, old_k, mid_k, new_k)) bad = gap;
        check(busy == 1'b1, "R4", "busy after write", int'(busy), 1);
        while (busy && waited < 2000) begin
            step();
            waited++;
            if (got && !gap_in(gap, old_k, mid_k, new_k)) bad = gap;
        end
        check(waited <= (1 << m), "R6", "switch delay", waited, 1 << m);
        check(bad < 0, (pre_k >= 0) ? "R9" : "R7", "spacing during change", bad, 1 << new_k);
        expect_gaps(2, new_k, "R1 R3 R8");
        cur_tb = new_k;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
            finish_run();
        end
    end

    initial begin
        // R2: reset state
        for (int i = 0; i < 4; i++) step();
        check(en == 1'b0, "R2", "enable in reset", int'(en), 0);
        check(busy == 1'b0, "R2", "busy in reset", int'(busy), 0);
        rst = 1'b0;
        last_tick = -1;
        expect_gaps(4, 3, "R2");

        // R3 R6 R7 R8: every old/new pair
        for (int o = 0; o <= 8; o++) begin
            for (int n = 0; n <= 8; n++) begin
                apply(-1, o);
                apply(-1, n);
            end
        end

        // R5: codes 9..15 are ignored
        apply(-1, 2);
        for (int c = 9; c <= 15; c++) begin
            write(c);
            check(busy == 1'b0, "R5", "busy after bad code", int'(busy), 0);
            expect_gaps(2, 2, "R5");
        end

        // R9: a second write while busy replaces the target
        apply(7, 1);
        apply(0, 6);
        apply(8, 4);

        done = 1'b1;
        finish_run();
    end
endmodule